// File: doc/BRIEF.md
# Graphics Pixel Colour Lookup Unit

This block turns a stream of packed graphics pixel codes into colour words for an on-screen graphics plane. Each input byte carries four 2-bit codes, two 4-bit codes or one 8-bit code, as set by the depth control. The block unpacks the byte and emits one pixel per clock. Each pixel code is then turned into an index into a colour table of up to 256 entries. The table returns luma, two chroma components and a transparency value for a later mixing stage.

For the narrow depths, an optional remap table can stand between the code and the colour table. The remap table lets a small code space pick any subset of a larger palette. Three fixed remap variants exist: sixteen codes into 256 colours, four codes into 256 colours, and four codes into the first sixteen colours. A host loads both tables through one write port. Run-length decoding, placement of graphics regions and blending with video all happen outside this block.

Top module: `gfx_clut_lookup`

## Requirements
- R1: After synchronous reset, `in_ready` is 1, `out_valid` is 0, all colour outputs are 0, and every colour-table and remap-table entry reads as zero.
- R2: `cfg_depth` selects the bits per pixel: 2'b00 = 2 bits, 2'b01 = 4 bits, 2'b1x = 8 bits. This gives 4, 2 or 1 pixels per byte, taken most significant field first. The depth is captured when the byte is accepted. `in_ready` is low while pixels of the current byte remain, and bytes offered then are ignored.
- R3: A pixel emitted in cycle c appears with `out_valid` high in cycle c+2. Consecutive pixels leave at one per cycle with no gaps.
- R4: When `cfg_remap` is 2'b00, or the accepted depth is 8 bits, the pixel code is used directly as the colour-table index.
- R5: When `cfg_remap` is 2'b01 (16 into 256), remap entry `code[3:0]` supplies the full 8-bit colour index.
- R6: When `cfg_remap` is 2'b10 (4 into 256), remap entry `code[1:0]` supplies the full 8-bit colour index. Upper code bits are ignored.
- R7: When `cfg_remap` is 2'b11 (4 into 16), the low 4 bits of remap entry `code[1:0]` form the index, and the upper index bits are 0.
- R8: A colour-table entry is written as `wr_data` = {Y[29:22], U[21:14], V[13:6], T[5:0]}. The fields leave on `out_y`, `out_u`, `out_v` and the 6-bit `out_t` (64 blend levels).
- R9: A table write takes effect for the next pixel that reads that table. A pixel that reads an entry in the same cycle it is written gets the old contents.
- R10: In a cycle with no output pixel, `out_valid` is 0 and the colour outputs hold their last value.
- R11: `wr_en` = 1 with `wr_target` = 0 writes colour entry `wr_addr`. With `wr_target` = 1 it writes remap entry `wr_addr[3:0]` with `wr_data[7:0]`. With `wr_en` = 0 nothing is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_depth | input | 2 | Bits-per-pixel select |
| cfg_remap | input | 2 | Remap variant select |
| wr_en | input | 1 | Host table write strobe |
| wr_target | input | 1 | 0 = colour table, 1 = remap table |
| wr_addr | input | 8 | Table entry address |
| wr_data | input | 30 | Entry contents |
| in_valid | input | 1 | Packed byte offered |
| in_byte | input | 8 | Packed pixel byte |
| in_ready | output | 1 | Byte accepted this cycle when valid |
| out_valid | output | 1 | Colour word valid |
| out_y | output | 8 | Luma |
| out_u | output | 8 | Blue-difference chroma |
| out_v | output | 8 | Red-difference chroma |
| out_t | output | 6 | Transparency |

## Verification
A wrong unpacker count shows up at `in_ready` in the cycle after a byte is accepted. It also shows at the outputs two cycles later as a missing pixel, an extra pixel or a pixel from the wrong field. A corrupted remap or colour entry shows up as a wrong colour word exactly two cycles after the first pixel that uses it. Read-versus-write ordering errors are caught by pixels that read an entry in the same cycle as its write, and by the pixel that reads it in the cycle after.

// File: rtl/gfx_clut_pkg.sv
package gfx_clut_pkg;

    localparam int PIX_W   = 8;
    localparam int COMP_W  = 8;
    localparam int ALPHA_W = 6;

    typedef struct packed {
        logic [COMP_W-1:0]  y;
        logic [COMP_W-1:0]  u;
        logic [COMP_W-1:0]  v;
        logic [ALPHA_W-1:0] t;
    } yuvt_t;

    localparam int WORD_W = $bits(yuvt_t);

    typedef enum logic [1:0] {
        DEPTH_2  = 2'b00,
        DEPTH_4  = 2'b01,
        DEPTH_8  = 2'b10,
        DEPTH_8B = 2'b11
    } depth_e;

    typedef enum logic [1:0] {
        REMAP_OFF    = 2'b00,
        REMAP_16_256 = 2'b01,
        REMAP_4_256  = 2'b10,
        REMAP_4_16   = 2'b11
    } remap_e;

    // Field width in bits for a depth setting
    function automatic logic [3:0] depth_bits(depth_e d);
        case (d)
            DEPTH_2: return 4'd2;
            DEPTH_4: return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

    // Pixels still to come after the first one of a byte
    function automatic logic [1:0] depth_rest(depth_e d);
        case (d)
            DEPTH_2: return 2'd3;
            DEPTH_4: return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

    // Leading field of a byte, right-aligned
    function automatic logic [PIX_W-1:0] depth_code(depth_e d, logic [PIX_W-1:0] b);
        case (d)
            DEPTH_2: return {6'b0, b[7:6]};
            DEPTH_4: return {4'b0, b[7:4]};
            default: return b;
        endcase
    endfunction

endpackage

// File: rtl/gfx_pixel_unpack.sv
module gfx_pixel_unpack
    import gfx_clut_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  depth_e           cfg_depth,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_byte,
    output logic             in_ready,
    output logic             pix_vld,
    output logic [PIX_W-1:0] pix_code,
    output depth_e           pix_depth
);

    logic [PIX_W-1:0] hold_q;
    logic [1:0]       left_q;
    depth_e           depth_q;
    logic [PIX_W-1:0] src;

    always_comb begin
        in_ready = (left_q == 2'd0);
        if (in_ready) begin
            src       = in_byte;
            pix_depth = cfg_depth;
            pix_vld   = in_valid;
        end else begin
            src       = hold_q;
            pix_depth = depth_q;
            pix_vld   = 1'b1;
        end
        pix_code = depth_code(pix_depth, src);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            left_q  <= '0;
            depth_q <= DEPTH_8;
        end else if (pix_vld) begin
            hold_q  <= src << depth_bits(pix_depth);
            depth_q <= pix_depth;
            left_q  <= in_ready ? depth_rest(pix_depth) : left_q - 2'd1;
        end
    end

    // R2
    two_bit_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && cfg_depth == DEPTH_2) |=> !in_ready);

    // R2
    full_byte_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && cfg_depth[1]) |=> in_ready);

endmodule

// File: rtl/gfx_index_map.sv
module gfx_index_map
    import gfx_clut_pkg::*;
#(
    parameter int CLUT_AW     = 8,
    parameter int MAP_ENTRIES = 16,
    parameter int NARROW_AW   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [$clog2(MAP_ENTRIES)-1:0] wr_addr,
    input  logic [CLUT_AW-1:0] wr_data,
    input  remap_e             mode,
    input  logic               pix_vld,
    input  logic [PIX_W-1:0]   pix_code,
    input  depth_e             pix_depth,
    output logic               idx_vld,
    output logic [CLUT_AW-1:0] idx
);

    localparam int MAP_AW = $clog2(MAP_ENTRIES);

    logic [CLUT_AW-1:0] tbl [MAP_ENTRIES];
    logic [CLUT_AW-1:0] wide_ent;
    logic [CLUT_AW-1:0] small_ent;
    logic [CLUT_AW-1:0] idx_d;

    always_comb begin
        wide_ent  = tbl[pix_code[MAP_AW-1:0]];
        small_ent = tbl[MAP_AW'(pix_code[1:0])];
        if (mode == REMAP_OFF || pix_depth[1]) begin
            idx_d = CLUT_AW'(pix_code);
        end else begin
            case (mode)
                REMAP_16_256: idx_d = wide_ent;
                REMAP_4_256:  idx_d = small_ent;
                default:      idx_d = CLUT_AW'(small_ent[NARROW_AW-1:0]);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MAP_ENTRIES; i++) tbl[i] <= '0;
            idx_vld <= 1'b0;
            idx     <= '0;
        end else begin
            if (wr_en) tbl[wr_addr] <= wr_data;
            idx_vld <= pix_vld;
            if (pix_vld) idx <= idx_d;
        end
    end

    // R7
    narrow_index_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_vld && mode == REMAP_4_16 && !pix_depth[1])
            |=> (idx[CLUT_AW-1:NARROW_AW] == '0));

endmodule

// File: rtl/gfx_colour_table.sv
module gfx_colour_table
    import gfx_clut_pkg::*;
#(
    parameter int CLUT_AW = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [CLUT_AW-1:0] wr_addr,
    input  yuvt_t              wr_data,
    input  logic               rd_vld,
    input  logic [CLUT_AW-1:0] rd_idx,
    output logic               out_vld,
    output yuvt_t              out_word
);

    localparam int CLUT_DEPTH = 1 << CLUT_AW;

    yuvt_t mem [CLUT_DEPTH];

    // Read and write share one edge: the read sees the old entry
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CLUT_DEPTH; i++) mem[i] <= '0;
            out_vld  <= 1'b0;
            out_word <= '0;
        end else begin
            if (wr_en) mem[wr_addr] <= wr_data;
            out_vld <= rd_vld;
            if (rd_vld) out_word <= mem[rd_idx];
        end
    end

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_vld |=> (!out_vld && $stable(out_word)));

endmodule

// File: rtl/gfx_clut_lookup.sv
module gfx_clut_lookup
    import gfx_clut_pkg::*;
#(
    parameter int CLUT_AW     = 8,
    parameter int MAP_ENTRIES = 16,
    parameter int NARROW_AW   = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          cfg_depth,
    input  logic [1:0]          cfg_remap,
    input  logic                wr_en,
    input  logic                wr_target,
    input  logic [CLUT_AW-1:0]  wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                in_valid,
    input  logic [PIX_W-1:0]    in_byte,
    output logic                in_ready,
    output logic                out_valid,
    output logic [COMP_W-1:0]   out_y,
    output logic [COMP_W-1:0]   out_u,
    output logic [COMP_W-1:0]   out_v,
    output logic [ALPHA_W-1:0]  out_t
);

    localparam int MAP_AW = $clog2(MAP_ENTRIES);

    logic             pix_vld;
    logic [PIX_W-1:0] pix_code;
    depth_e           pix_depth;
    logic             idx_vld;
    logic [CLUT_AW-1:0] idx;
    yuvt_t            word;

    gfx_pixel_unpack u_unpack (
        .clk       (clk),
        .rst       (rst),
        .cfg_depth (depth_e'(cfg_depth)),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .in_ready  (in_ready),
        .pix_vld   (pix_vld),
        .pix_code  (pix_code),
        .pix_depth (pix_depth)
    );

    gfx_index_map #(
        .CLUT_AW     (CLUT_AW),
        .MAP_ENTRIES (MAP_ENTRIES),
        .NARROW_AW   (NARROW_AW)
    ) u_map (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en && wr_target),
        .wr_addr   (wr_addr[MAP_AW-1:0]),
        .wr_data   (wr_data[CLUT_AW-1:0]),
        .mode      (remap_e'(cfg_remap)),
        .pix_vld   (pix_vld),
        .pix_code  (pix_code),
        .pix_depth (pix_depth),
        .idx_vld   (idx_vld),
        .idx       (idx)
    );

    gfx_colour_table #(
        .CLUT_AW (CLUT_AW)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en && !wr_target),
        .wr_addr  (wr_addr),
        .wr_data  (yuvt_t'(wr_data)),
        .rd_vld   (idx_vld),
        .rd_idx   (idx),
        .out_vld  (out_valid),
        .out_word (word)
    );

    assign out_y = word.y;
    assign out_u = word.u;
    assign out_v = word.v;
    assign out_t = word.t;

    // R3
    fixed_latency_chk: assert property (@(posedge clk) disable iff (rst)
        pix_vld |-> ##2 out_valid);

endmodule

// File: tb/test_gfx_clut_lookup.sv
module test_gfx_clut_lookup;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_depth = 2'b10;
    logic [1:0]  cfg_remap = 2'b00;
    logic        wr_en = 1'b0;
    logic        wr_target = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [29:0] wr_data = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_y, out_u, out_v;
    logic [5:0]  out_t;

    gfx_clut_lookup i_gfx_clut_lookup (
        .clk(clk), .rst(rst), .cfg_depth(cfg_depth), .cfg_remap(cfg_remap),
        .wr_en(wr_en), .wr_target(wr_target), .wr_addr(wr_addr), .wr_data(wr_data),
        .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
        .out_valid(out_valid), .out_y(out_y), .out_u(out_u), .out_v(out_v), .out_t(out_t)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Bench model
    logic [29:0] m_clut [256];
    logic [7:0]  m_map  [16];
    logic [7:0]  m_hold;
    logic [1:0]  m_left;
    logic [1:0]  m_depth;
    logic        s0_v;
    logic [7:0]  s0_idx;
    logic        s1_v;
    logic [29:0] s1_w;
    logic [29:0] last_w;

    function automatic logic [29:0] pat(int i);
        logic [7:0] b = 8'(i);
        return {b, ~b, b ^ 8'h5a, b[5:0] ^ 6'h2a};
    endfunction

    function automatic int width_of(logic [1:0] d);
        return (d == 2'b00) ? 2 : (d == 2'b01) ? 4 : 8;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 256; i++) m_clut[i] = '0;
        for (int i = 0; i < 16; i++) m_map[i] = '0;
        m_hold = '0; m_left = '0; m_depth = 2'b10;
        s0_v = 0; s0_idx = '0; s1_v = 0; s1_w = '0; last_w = '0;
    endtask

    // One clock cycle: check outputs, advance model, drive inputs
    task automatic step(input bit v, input logic [7:0] b, input bit we, input bit tgt,
                        input logic [7:0] a, input logic [29:0] d, input string tag);
        bit em;
        logic [7:0] src, code, idx;
        logic [1:0] dsel;
        int w;
        check(out_valid === s1_v, tag, "out_valid", 32'(out_valid), 32'(s1_v));
        check({out_y, out_u, out_v, out_t} === s1_w, tag, "colour",
              32'({out_y, out_u, out_v, out_t}), 32'(s1_w));
        check(in_ready === (m_left == 0), "R2", "in_ready", 32'(in_ready), 32'(m_left == 0));
        // CLUT read of last cycle's pixel happens now, before this cycle's write
        if (s0_v) begin
            s1_v = 1; s1_w = m_clut[s0_idx]; last_w = s1_w;
        end else begin
            s1_v = 0; s1_w = last_w;
        end
        em = 0; src = '0; dsel = m_depth;
        if (m_left == 0) begin
            if (v) begin em = 1; src = b; dsel = cfg_depth; end
        end else begin
            em = 1; src = m_hold; dsel = m_depth;
        end
        s0_v = em; s0_idx = '0;
        if (em) begin
            w = width_of(dsel);
            code = src >> (8 - w);
            if (cfg_remap == 2'b00 || w == 8) idx = code;
            else if (cfg_remap == 2'b01) idx = m_map[code[3:0]];
            else if (cfg_remap == 2'b10) idx = m_map[{2'b00, code[1:0]}];
            else idx = {4'b0000, m_map[{2'b00, code[1:0]}][3:0]};
            s0_idx = idx;
            m_hold = src << w;
            m_left = (m_left == 0) ? 2'(8 / w - 1) : m_left - 2'd1;
            m_depth = dsel;
        end
        in_valid = v; in_byte = b;
        wr_en = we; wr_target = tgt; wr_addr = a; wr_data = d;
        if (we) begin
            if (tgt) m_map[a[3:0]] = d[7:0];
            else m_clut[a] = d;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic px(input logic [7:0] b, input string tag);
        step(1, b, 0, 0, 8'h00, 30'h0, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, 8'h00, 30'h0, tag);
    endtask

    task automatic busy_junk(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1, 8'h55, 0, 0, 8'h00, 30'h0, tag);
    endtask

    task automatic t_reset();
        rst = 1; in_valid = 0; wr_en = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        check(in_ready === 1'b1, "R1", "in_ready after reset", 32'(in_ready), 32'h1);
        check(out_valid === 1'b0, "R1", "out_valid after reset", 32'(out_valid), 32'h0);
        check({out_y, out_u, out_v, out_t} === 30'h0, "R1", "colour after reset",
              32'({out_y, out_u, out_v, out_t}), 32'h0);
        cfg_depth = 2'b10; cfg_remap = 2'b00;
        px(8'h00, "R1"); px(8'h37, "R1"); px(8'hff, "R1");
        cfg_depth = 2'b00; cfg_remap = 2'b01;
        px(8'hb4, "R1"); busy_junk(3, "R1");
        idle(2, "R1");
    endtask

    task automatic t_load();
        for (int i = 0; i < 256; i++) step(0, 8'h00, 1, 0, 8'(i), pat(i), "R11");
        for (int j = 0; j < 16; j++) step(0, 8'h00, 1, 1, 8'(j), 30'(8'd250 - 8'(j * 13)), "R11");
        // disabled write must leave entry 3 untouched
        step(0, 8'h00, 0, 0, 8'h03, 30'h3fffffff, "R11");
        step(0, 8'h00, 0, 1, 8'h03, 30'h000000ff, "R11");
        cfg_depth = 2'b10; cfg_remap = 2'b00;
        px(8'h03, "R11");
        cfg_depth = 2'b01; cfg_remap = 2'b01;
        px(8'h33, "R11"); busy_junk(1, "R11");
        idle(2, "R11");
    endtask

    task automatic t_direct8();
        cfg_depth = 2'b10; cfg_remap = 2'b00;
        px(8'h03, "R4"); px(8'h80, "R4"); px(8'hff, "R4"); px(8'h5a, "R4");
        idle(2, "R4");
        px(8'h37, "R8"); px(8'hc1, "R8");
        idle(2, "R8");
    endtask

    task automatic t_pack();
        cfg_depth = 2'b00; cfg_remap = 2'b00;
        px(8'hd8, "R2"); busy_junk(3, "R2");
        px(8'h1b, "R3"); busy_junk(3, "R3");
        px(8'he4, "R3"); busy_junk(3, "R3");
        cfg_depth = 2'b01;
        px(8'ha7, "R2"); busy_junk(1, "R2");
        px(8'h3c, "R3"); busy_junk(1, "R3");
        idle(3, "R3");
    endtask

    task automatic t_map16();
        cfg_depth = 2'b01; cfg_remap = 2'b01;
        px(8'h0f, "R5"); busy_junk(1, "R5");
        px(8'h93, "R5"); busy_junk(1, "R5");
        cfg_depth = 2'b00;
        px(8'h6c, "R5"); busy_junk(3, "R5");
        idle(2, "R5");
    endtask

    task automatic t_map4_256();
        cfg_depth = 2'b00; cfg_remap = 2'b10;
        px(8'he4, "R6"); busy_junk(3, "R6");
        cfg_depth = 2'b01;
        px(8'h6d, "R6"); busy_junk(1, "R6");
        idle(2, "R6");
    endtask

    task automatic t_map4_16();
        cfg_depth = 2'b00; cfg_remap = 2'b11;
        px(8'h1b, "R7"); busy_junk(3, "R7");
        cfg_depth = 2'b01;
        px(8'hf2, "R7"); busy_junk(1, "R7");
        idle(2, "R7");
    endtask

    task automatic t_bypass8();
        cfg_depth = 2'b10; cfg_remap = 2'b01;
        px(8'h0c, "R4"); px(8'h02, "R4");
        cfg_depth = 2'b11; cfg_remap = 2'b11;
        px(8'h0e, "R4");
        idle(2, "R4");
    endtask

    task automatic t_depth_change();
        cfg_depth = 2'b00; cfg_remap = 2'b00;
        px(8'h9c, "R2");
        cfg_depth = 2'b10;
        busy_junk(3, "R2");
        px(8'h9c, "R2");
        idle(2, "R2");
    endtask

    task automatic t_collide();
        cfg_depth = 2'b10; cfg_remap = 2'b00;
        px(8'h05, "R9");
        step(1, 8'h05, 1, 0, 8'h05, 30'h2aa_aaaa, "R9");
        px(8'h05, "R9");
        idle(2, "R9");
        cfg_depth = 2'b01; cfg_remap = 2'b01;
        step(1, 8'h22, 1, 1, 8'h02, 30'h0000_0077, "R9");
        busy_junk(1, "R9");
        idle(2, "R9");
    endtask

    task automatic t_idle();
        cfg_depth = 2'b10; cfg_remap = 2'b00;
        px(8'h44, "R10");
        idle(4, "R10");
        px(8'h45, "R10");
        step(0, 8'h00, 1, 0, 8'h45, 30'h0, "R10");
        idle(3, "R10");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_load();
        t_direct8();
        t_pack();
        t_map16();
        t_map4_256();
        t_map4_16();
        t_bypass8();
        t_depth_change();
        t_collide();
        t_idle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule